// File: doc/BRIEF.md
# External Interrupt Sense Logic

This block turns a small set of dedicated interrupt pins into interrupt requests. Each pin has a two-bit sense field. The field selects one of four triggers: a low level, any edge, a falling edge or a rising edge. The edge triggers pass the pin through a synchronizer, then compare it against a registered copy of its previous value. A matching edge sets a sticky flag, and software clears that flag by writing a one to the pin's clear strobe.

The low-level trigger works differently. It is taken straight from the raw pin without a clock, so it can still raise a request while the I/O clock is stopped. It keeps no state, and its request goes away as soon as the pin returns high. Edge detection runs only while the clock-running indication is high; an edge that occurs while the clock is stopped is lost.

The previous-value register follows the pin in every mode. Changing a pin's sense field therefore never creates a false flag. A per-pin enable gates each request at the output.

Top module: `extint_sense`

## Requirements
- R1: After reset, with all pins held high, every request is 0 and no flag is set.
- R2: With sense code 00 (low level) and the pin enabled, the request equals the inverse of the raw pin with no clock delay; it is not latched and drops as soon as the pin returns high.
- R3: The low-level request of R2 is raised even while the clock-running input is 0.
- R4: With sense code 10, a falling edge of the pin sets the pin's flag, and the request shows it at the third rising clock edge after the pin change; a rising edge sets nothing.
- R5: With sense code 11, a rising edge sets the flag with the same latency as R4; a falling edge sets nothing.
- R6: With sense code 01, both a falling and a rising edge set the flag.
- R7: A flag stays set until a one on the pin's clear strobe is sampled at a clock edge. If an edge sets the flag in the same cycle as the clear, the flag stays set.
- R8: Edges that occur while the clock-running input is 0 set no flag, and they are not reported after the clock resumes.
- R9: A disabled pin's request is 0. The flag is still recorded while the pin is disabled and appears as soon as the enable is set.
- R10: Changing a pin's sense field while the pin is steady never sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clkRun | input | 1 | High while the I/O clock is running; gates edge detection |
| pinIn | input | NUM_PINS | Raw interrupt pins |
| senseCtl | input | 2*NUM_PINS | Sense field per pin, pin i in bits 2i+1:2i |
| enable | input | NUM_PINS | Per-pin request enable |
| flagClr | input | NUM_PINS | Write-one clear strobe per flag |
| irqReq | output | NUM_PINS | Per-pin interrupt request |

## Verification
The pins are driven through single falling edges, single rising edges and full toggles under each sense code. These patterns show whether each code responds to the right edge direction and ignores the other one. Level-mode pulses are applied with the clock running and with it stopped, which shows that the low-level path is combinational and does not latch. Edges are also placed while the clock is gated, in the same cycle as a clear strobe, while the pin is disabled, and across a mode switch with the pin held low. These cases separate flag setting from clock gating, clear priority, output gating and stale previous-value tracking.

// File: rtl/extint_pkg.sv
package extint_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam int SENSE_W = 2;

  // Per-pin strobes from control to datapath
  typedef struct packed {
    logic setFlag;
    logic clrFlag;
    logic levelSel;
  } pinStrobe_t;

endpackage

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic [NUM_PINS-1:0]          syncQ,
  input  logic [NUM_PINS-1:0]          prevQ,
  input  logic [SENSE_W*NUM_PINS-1:0]  senseCtl,
  input  logic [NUM_PINS-1:0]          flagClr,
  input  logic                         clkRun,
  output pinStrobe_t [NUM_PINS-1:0]    strobes
);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    sense_e mode;
    logic   riseSeen;
    logic   fallSeen;
    logic   hit;

    assign mode     = sense_e'(senseCtl[SENSE_W*i +: SENSE_W]);
    assign riseSeen = syncQ[i] & ~prevQ[i];
    assign fallSeen = ~syncQ[i] & prevQ[i];

    always_comb begin
      case (mode)
        SENSE_ANY:  hit = riseSeen | fallSeen;
        SENSE_FALL: hit = fallSeen;
        SENSE_RISE: hit = riseSeen;
        default:    hit = 1'b0;
      endcase
    end

    assign strobes[i].setFlag  = hit & clkRun;
    assign strobes[i].clrFlag  = flagClr[i];
    assign strobes[i].levelSel = (mode == SENSE_LOW);
  end

endmodule

// File: rtl/extint_datapath.sv
module extint_datapath
  import extint_pkg::*;
#(
  parameter int   NUM_PINS    = 4,
  parameter int   SYNC_STAGES = 2,
  parameter logic IDLE_LEVEL  = 1'b1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PINS-1:0]        pinIn,
  input  logic [NUM_PINS-1:0]        enable,
  input  pinStrobe_t [NUM_PINS-1:0]  strobes,
  output logic [NUM_PINS-1:0]        syncQ,
  output logic [NUM_PINS-1:0]        prevQ,
  output logic [NUM_PINS-1:0]        irqReq
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_PINS-1:0] syncStage [SYNC_STAGES];
  logic [NUM_PINS-1:0] flagQ;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       syncStage[s] <= {NUM_PINS{IDLE_LEVEL}};
      else if (s == 0) syncStage[s] <= pinIn;
      else             syncStage[s] <= syncStage[(s == 0) ? 0 : s-1];
    end
  end

  assign syncQ = syncStage[LAST];

  // Previous value tracks the pin in every mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= {NUM_PINS{IDLE_LEVEL}};
    else       prevQ <= syncQ;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    flagQ[i] <= 1'b0;
      else if (strobes[i].setFlag)  flagQ[i] <= 1'b1;
      else if (strobes[i].clrFlag)  flagQ[i] <= 1'b0;
    end

    // Level request comes from the raw pin, no clock involved
    assign irqReq[i] = enable[i] & (strobes[i].levelSel ? ~pinIn[i] : flagQ[i]);
  end

endmodule

// File: rtl/extint_sense.sv
module extint_sense
  import extint_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        clkRun,
  input  logic [NUM_PINS-1:0]         pinIn,
  input  logic [SENSE_W*NUM_PINS-1:0] senseCtl,
  input  logic [NUM_PINS-1:0]         enable,
  input  logic [NUM_PINS-1:0]         flagClr,
  output logic [NUM_PINS-1:0]         irqReq
);

  logic [NUM_PINS-1:0]       syncQ;
  logic [NUM_PINS-1:0]       prevQ;
  pinStrobe_t [NUM_PINS-1:0] strobes;

  extint_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .syncQ    (syncQ),
    .prevQ    (prevQ),
    .senseCtl (senseCtl),
    .flagClr  (flagClr),
    .clkRun   (clkRun),
    .strobes  (strobes)
  );

  extint_datapath #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .enable  (enable),
    .strobes (strobes),
    .syncQ   (syncQ),
    .prevQ   (prevQ),
    .irqReq  (irqReq)
  );

endmodule

// File: rtl/extint_sense_chk.sv
module extint_sense_chk
  import extint_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        clkRun,
  input logic [NUM_PINS-1:0]         pinIn,
  input logic [SENSE_W*NUM_PINS-1:0] senseCtl,
  input logic [NUM_PINS-1:0]         enable,
  input logic [NUM_PINS-1:0]         flagClr,
  input logic [NUM_PINS-1:0]         irqReq
);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [SENSE_W-1:0] fieldNow;
    assign fieldNow = senseCtl[SENSE_W*i +: SENSE_W];

    // R2
    level_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
      (fieldNow == SENSE_LOW && enable[i]) |-> (irqReq[i] == ~pinIn[i]));

    // R8
    gated_no_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!clkRun && fieldNow != SENSE_LOW && !irqReq[i])
      |=> (!irqReq[i] || !$stable(enable) || !$stable(senseCtl)));

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      (fieldNow != SENSE_LOW && irqReq[i] && !flagClr[i])
      |=> (irqReq[i] || !$stable(enable) || !$stable(senseCtl)));

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (flagClr[i] && !clkRun && fieldNow != SENSE_LOW)
      |=> (!irqReq[i] || !$stable(senseCtl)));
  end

endmodule

bind extint_sense extint_sense_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .clkRun   (clkRun),
  .pinIn    (pinIn),
  .senseCtl (senseCtl),
  .enable   (enable),
  .flagClr  (flagClr),
  .irqReq   (irqReq)
);

// File: tb/extint_sense_tb.sv
`timescale 1ns/1ps
module extint_sense_tb;

  localparam int N = 4;

  typedef struct {
    string    tag;
    logic [N-1:0] exp;
  } item_t;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           clkRun = 1'b1;
  logic [N-1:0]   pinIn = '1;
  logic [2*N-1:0] senseCtl = 8'h55;
  logic [N-1:0]   enable = '1;
  logic [N-1:0]   flagClr = '0;
  logic [N-1:0]   irqReq;

  item_t expQ[$];
  int    applied = 0;
  int    miscmp  = 0;
  bit    doneRun = 1'b0;

  always #4 clk = ~clk;

  extint_sense #(.NUM_PINS(N)) u_dut (
    .clk(clk), .rstN(rstN), .clkRun(clkRun), .pinIn(pinIn),
    .senseCtl(senseCtl), .enable(enable), .flagClr(flagClr), .irqReq(irqReq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver side: push expected item, monitor compares
  task automatic expect_irq(input string tag, input logic [N-1:0] exp);
    item_t it;
    #1;
    it.tag = tag;
    it.exp = exp;
    expQ.push_back(it);
    wait (expQ.size() == 0);
  endtask

  task automatic clear_flag(input logic [N-1:0] m);
    flagClr = m;
    tick(1);
    flagClr = '0;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      wait (expQ.size() != 0);
      it = expQ.pop_front();
      applied++;
      if (irqReq !== it.exp) begin
        miscmp++;
        $display("FAIL %s: irqReq=%b expected=%b", it.tag, irqReq, it.exp);
      end
    end
  end

  initial begin : watchdog
    #200000;
    if (!doneRun) begin
      miscmp++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
      $finish;
    end
  end

  initial begin : stimulus
    tick(2);
    rstN = 1'b1;
    tick(4);
    expect_irq("R1 reset idle", 4'b0000);

    // R2 level mode on pin0
    senseCtl = 8'b01_01_01_00;
    expect_irq("R10 switch to level, pin high", 4'b0000);
    pinIn[0] = 1'b0;
    expect_irq("R2 level low raises request", 4'b0001);
    pinIn[0] = 1'b1;
    expect_irq("R2 level not latched", 4'b0000);
    // R3 clock stopped
    clkRun = 1'b0;
    pinIn[0] = 1'b0;
    expect_irq("R3 level with clock halted", 4'b0001);
    pinIn[0] = 1'b1;
    clkRun = 1'b1;
    tick(4);

    // R4 falling on pin1
    senseCtl = 8'b01_01_10_00;
    tick(4);
    expect_irq("R10 mode change steady pin", 4'b0000);
    tick(1);
    pinIn[1] = 1'b0;
    tick(2);
    expect_irq("R4 latency not yet", 4'b0000);
    tick(1);
    expect_irq("R4 falling sets flag", 4'b0010);
    pinIn[1] = 1'b1;
    tick(4);
    expect_irq("R7 flag sticky", 4'b0010);
    clear_flag(4'b0010);
    expect_irq("R7 clear strobe", 4'b0000);
    tick(4);
    expect_irq("R4 rising ignored", 4'b0000);

    // R5 rising on pin2
    senseCtl = 8'b01_11_10_00;
    tick(1);
    pinIn[2] = 1'b0;
    tick(4);
    expect_irq("R5 falling ignored", 4'b0000);
    pinIn[2] = 1'b1;
    tick(2);
    expect_irq("R5 latency not yet", 4'b0000);
    tick(1);
    expect_irq("R5 rising sets flag", 4'b0100);
    clear_flag(4'b0100);
    expect_irq("R5 cleared", 4'b0000);

    // R6 any edge on pin3
    pinIn[3] = 1'b0;
    tick(3);
    expect_irq("R6 falling edge", 4'b1000);
    clear_flag(4'b1000);
    pinIn[3] = 1'b1;
    tick(3);
    expect_irq("R6 rising edge", 4'b1000);
    clear_flag(4'b1000);
    expect_irq("R6 cleared", 4'b0000);

    // R7 set wins over clear in the same cycle
    pinIn[3] = 1'b0;
    tick(2);
    flagClr = 4'b1000;
    tick(1);
    flagClr = '0;
    expect_irq("R7 set beats clear", 4'b1000);
    clear_flag(4'b1000);
    pinIn[3] = 1'b1;
    tick(4);
    clear_flag(4'b1000);
    expect_irq("R7 clean state", 4'b0000);

    // R8 edges while clock gated are lost
    clkRun = 1'b0;
    pinIn[2] = 1'b0;
    tick(4);
    pinIn[2] = 1'b1;
    tick(4);
    expect_irq("R8 gated edge not flagged", 4'b0000);
    clkRun = 1'b1;
    tick(4);
    expect_irq("R8 not reported after resume", 4'b0000);

    // R9 enable gating
    enable = 4'b0111;
    pinIn[3] = 1'b0;
    tick(3);
    expect_irq("R9 disabled pin silent", 4'b0000);
    enable = 4'b1111;
    expect_irq("R9 recorded flag appears", 4'b1000);
    clear_flag(4'b1000);
    pinIn[3] = 1'b1;
    tick(4);
    clear_flag(4'b1000);

    // R10 mode switch with pin low
    pinIn[0] = 1'b0;
    expect_irq("R2 level pin0 low", 4'b0001);
    senseCtl = 8'b01_11_10_11;
    tick(4);
    expect_irq("R10 no spurious flag", 4'b0000);
    pinIn[0] = 1'b1;
    tick(3);
    expect_irq("R10 later rising still seen", 4'b0001);
    clear_flag(4'b0001);
    expect_irq("R10 cleared", 4'b0000);

    doneRun = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  end

endmodule